// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block sits between a memory controller and the DRAM devices on a module. It captures the address and command lines on the rising clock edge and drives the registered values out. Two static configuration pins choose how the captured bits reach the outputs:

- a wide one-to-one layout, where every input has one output;
- a narrow one-to-two layout, where each input drives an A copy and a B copy. This layout comes in a front arrangement and a back arrangement, and the back arrangement reorders the bits.

A pair of select inputs can freeze the data outputs to save switching power. While both selects are high, the data outputs keep their values. The on-die-termination output, the clock-enable output and the registered select output still follow their inputs on every edge. An active-low asynchronous reset clears every register and forces all outputs low at once, without waiting for a clock. Reset takes precedence over the select gating. The configuration pins may change only while reset is held.

Top module: `cmdbuf_regbuf`

## Requirements
- R1: In the one-to-one layout (`{cfg_side,cfg_split}` = 00), `q_a` equals the value of `d_in` captured at the previous rising edge of `clk`.
- R2: When `cs_main` and `cs_aux` are both 1 at a rising edge, `q_a` and `q_b` keep the values they had before that edge.
- R3: When `cs_main` or `cs_aux` is 0 at a rising edge, the data register loads `d_in`. Holding `cs_aux` at 0 therefore makes the block a plain register.
- R4: On every rising edge, `qcs_a` loads `cs_main`, `qodt_a` loads `odt_in` and `qcke_a` loads `cke_in`, whatever the state of the gating.
- R5: While `rst_n` is 0, every output is 0. This takes effect as soon as `rst_n` falls, before any clock edge, and it holds even when both selects are 1.
- R6: In the front layout (code 01), `q_a[13:0]` and `q_b` both equal the captured `d_in[13:0]`, `q_a[24:14]` is 0, and each B control output equals its A twin.
- R7: In the back layout (code 11), output bit i of `q_a` and of `q_b` equals captured `d_in[13-i]`, and `q_a[24:14]` is 0. The B control outputs equal their A twins.
- R8: In the reserved code 10, `q_a`, `q_b` and the three B control outputs are 0. The A control outputs still update as in R4.
- R9: In the one-to-one layout, `q_b` and the three B control outputs are 0.
- R10: When reset is released while `d_in`, `odt_in` and `cke_in` are held low and `cs_main` is low, every output stays 0 on the following edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_side | input | 1 | Configuration bit: selects the back arrangement in the one-to-two layout |
| cfg_split | input | 1 | Configuration bit: selects the one-to-two layout |
| d_in | input | 25 | Address and command data inputs |
| cs_main | input | 1 | Primary select; also feeds the registered select output |
| cs_aux | input | 1 | Secondary select; the data outputs freeze when this and cs_main are both high |
| odt_in | input | 1 | Termination control input, exempt from gating |
| cke_in | input | 1 | Clock-enable input, exempt from gating |
| q_a | output | 25 | Registered data, A copy (all bits in the one-to-one layout) |
| q_b | output | 14 | Registered data, B copy |
| qcs_a | output | 1 | Registered cs_main, A copy |
| qcs_b | output | 1 | Registered cs_main, B copy |
| qodt_a | output | 1 | Registered odt_in, A copy |
| qodt_b | output | 1 | Registered odt_in, B copy |
| qcke_a | output | 1 | Registered cke_in, A copy |
| qcke_b | output | 1 | Registered cke_in, B copy |

## Verification
Assertions check on every cycle the behaviours that follow from the previous edge:

- the frozen data register when both selects are high;
- loading of the data register otherwise;
- the always-updating control bits;
- zero outputs throughout reset;
- the cleared upper bits and matching B controls in the split layouts.

Only the bench scenarios can show that reset clears the outputs in the middle of a cycle, before any edge. The same holds for the exact bit reordering of the back layout, the all-zero data in the reserved code, and the quiet outputs after reset is released with low inputs.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    // Layout code formed as {cfg_side, cfg_split}
    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_FRONT  = 2'b01,
        MODE_RSVD   = 2'b10,
        MODE_BACK   = 2'b11
    } mode_e;

    typedef struct packed {
        logic cs;
        logic odt;
        logic cke;
    } ctrl_t;

    localparam ctrl_t CTRL_ZERO = '{cs: 1'b0, odt: 1'b0, cke: 1'b0};

    function automatic mode_e decode_mode(input logic side, input logic split);
        return mode_e'({side, split});
    endfunction

    // Source bit feeding output position pos in the back arrangement
    function automatic int back_src(input int pos, input int width);
        return width - 1 - pos;
    endfunction

endpackage

// File: rtl/cmdbuf_capture.sv
module cmdbuf_capture
    import cmdbuf_pkg::*;
#(
    parameter int WIDE_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDE_W-1:0] d_in,
    input  logic              cs_main,
    input  logic              cs_aux,
    input  logic              odt_in,
    input  logic              cke_in,
    output logic [WIDE_W-1:0] data_q,
    output ctrl_t             ctrl_q
);

    logic gate_hold;
    assign gate_hold = cs_main & cs_aux;

    // Gated data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (!gate_hold) begin
            data_q <= d_in;
        end
    end

    // Exempt control register, loads every edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_ZERO;
        end else begin
            ctrl_q <= '{cs: cs_main, odt: odt_in, cke: cke_in};
        end
    end

    // R2
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_main && cs_aux) |=> $stable(data_q));

    // R3
    load_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_main && cs_aux) |=> (data_q == $past(d_in)));

    // R4
    ctrl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctrl_q.cs == $past(cs_main) && ctrl_q.odt == $past(odt_in)
                  && ctrl_q.cke == $past(cke_in)));

endmodule

// File: rtl/cmdbuf_fanout.sv
module cmdbuf_fanout
    import cmdbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  mode_e               mode,
    input  logic [WIDE_W-1:0]   data_q,
    input  ctrl_t               ctrl_q,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b,
    output ctrl_t               ctrl_a,
    output ctrl_t               ctrl_b
);

    logic [NARROW_W-1:0] front_w;
    logic [NARROW_W-1:0] back_w;

    for (genvar i = 0; i < NARROW_W; i++) begin : g_route
        assign front_w[i] = data_q[i];
        assign back_w[i]  = data_q[back_src(i, NARROW_W)];
    end

    always_comb begin
        q_a    = '0;
        q_b    = '0;
        ctrl_a = ctrl_q;
        ctrl_b = CTRL_ZERO;
        unique case (mode)
            MODE_DIRECT: begin
                q_a = data_q;
            end
            MODE_FRONT: begin
                q_a[NARROW_W-1:0] = front_w;
                q_b               = front_w;
                ctrl_b            = ctrl_q;
            end
            MODE_BACK: begin
                q_a[NARROW_W-1:0] = back_w;
                q_b               = back_w;
                ctrl_b            = ctrl_q;
            end
            default: begin
                q_a = '0;
                q_b = '0;
            end
        endcase
    end

endmodule

// File: rtl/cmdbuf_regbuf.sv
module cmdbuf_regbuf
    import cmdbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_side,
    input  logic                cfg_split,
    input  logic [WIDE_W-1:0]   d_in,
    input  logic                cs_main,
    input  logic                cs_aux,
    input  logic                odt_in,
    input  logic                cke_in,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b,
    output logic                qcs_a,
    output logic                qcs_b,
    output logic                qodt_a,
    output logic                qodt_b,
    output logic                qcke_a,
    output logic                qcke_b
);

    localparam int UPPER_W = WIDE_W - NARROW_W;

    mode_e               mode;
    logic [WIDE_W-1:0]   data_q;
    ctrl_t               ctrl_q;
    ctrl_t               ctrl_a;
    ctrl_t               ctrl_b;

    assign mode = decode_mode(cfg_side, cfg_split);

    cmdbuf_capture #(.WIDE_W(WIDE_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_in    (d_in),
        .cs_main (cs_main),
        .cs_aux  (cs_aux),
        .odt_in  (odt_in),
        .cke_in  (cke_in),
        .data_q  (data_q),
        .ctrl_q  (ctrl_q)
    );

    cmdbuf_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_fanout (
        .mode    (mode),
        .data_q  (data_q),
        .ctrl_q  (ctrl_q),
        .q_a     (q_a),
        .q_b     (q_b),
        .ctrl_a  (ctrl_a),
        .ctrl_b  (ctrl_b)
    );

    assign qcs_a  = ctrl_a.cs;
    assign qodt_a = ctrl_a.odt;
    assign qcke_a = ctrl_a.cke;
    assign qcs_b  = ctrl_b.cs;
    assign qodt_b = ctrl_b.odt;
    assign qcke_b = ctrl_b.cke;

    // Tracks that reset was already low at the previous edge
    logic rst_low_d;
    always_ff @(posedge clk) begin
        rst_low_d <= !rst_n;
    end

    // R5
    always @(posedge clk) begin
        if (!rst_n && rst_low_d) begin
            reset_quiet_chk: assert (q_a == '0 && q_b == '0 && !qcs_a && !qcs_b
                                     && !qodt_a && !qodt_b && !qcke_a && !qcke_b);
        end
    end

    // R6 R7
    split_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_split) |-> (q_a[WIDE_W-1:NARROW_W] == UPPER_W'(0)
                         && qodt_b == qodt_a && qcke_b == qcke_a && qcs_b == qcs_a));

    // R9
    direct_bside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_split && !cfg_side) |-> (q_b == '0 && !qcs_b && !qodt_b && !qcke_b));

endmodule

// File: tb/cmdbuf_regbuf_bench.sv
module cmdbuf_regbuf_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_side = 1'b0;
    logic        cfg_split = 1'b0;
    logic [24:0] d_in = '0;
    logic        cs_main = 1'b0;
    logic        cs_aux = 1'b0;
    logic        odt_in = 1'b0;
    logic        cke_in = 1'b0;
    logic [24:0] q_a;
    logic [13:0] q_b;
    logic        qcs_a, qcs_b, qodt_a, qodt_b, qcke_a, qcke_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdbuf_regbuf u_cmdbuf_regbuf (
        .clk(clk), .rst_n(rst_n), .cfg_side(cfg_side), .cfg_split(cfg_split),
        .d_in(d_in), .cs_main(cs_main), .cs_aux(cs_aux), .odt_in(odt_in),
        .cke_in(cke_in), .q_a(q_a), .q_b(q_b), .qcs_a(qcs_a), .qcs_b(qcs_b),
        .qodt_a(qodt_a), .qodt_b(qodt_b), .qcke_a(qcke_a), .qcke_b(qcke_b)
    );

    // {cs_main, cs_aux, odt, cke, d, expected q_a}
    typedef struct packed {
        logic        sm;
        logic        sx;
        logic        odt;
        logic        cke;
        logic [24:0] d;
        logic [24:0] exp_q;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 25'h1555555, 25'h1555555},
        '{1'b1, 1'b1, 1'b0, 1'b1, 25'h0123456, 25'h1555555},
        '{1'b1, 1'b0, 1'b1, 1'b1, 25'h0123456, 25'h0123456},
        '{1'b0, 1'b1, 1'b0, 1'b0, 25'h1FFFFFF, 25'h1FFFFFF},
        '{1'b1, 1'b1, 1'b1, 1'b0, 25'h0000000, 25'h1FFFFFF},
        '{1'b0, 1'b0, 1'b0, 1'b1, 25'h0ABCDEF, 25'h0ABCDEF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic all_low(input string tag);
        chk(tag, {7'b0, q_a}, 32'h0);
        chk(tag, {18'b0, q_b}, 32'h0);
        chk(tag, {26'b0, qcs_a, qcs_b, qodt_a, qodt_b, qcke_a, qcke_b}, 32'h0);
    endtask

    task automatic set_mode(input logic side, input logic split);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_side = side;
        cfg_split = split;
        d_in = '0; cs_main = 1'b0; cs_aux = 1'b0; odt_in = 1'b0; cke_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic sm, input logic sx, input logic o, input logic k,
                         input logic [24:0] d);
        cs_main = sm; cs_aux = sx; odt_in = o; cke_in = k; d_in = d;
        @(negedge clk);
    endtask

    initial begin
        // R5: reset state
        @(negedge clk);
        @(negedge clk);
        all_low("R5 reset state");
        rst_n = 1'b1;

        // R1 R2 R3 R4: table walk in one-to-one layout
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].sm, VECS[i].sx, VECS[i].odt, VECS[i].cke, VECS[i].d);
            chk("R1/R2/R3 q_a", {7'b0, q_a}, {7'b0, VECS[i].exp_q});
            chk("R4 ctrl", {29'b0, qcs_a, qodt_a, qcke_a},
                {29'b0, VECS[i].sm, VECS[i].odt, VECS[i].cke});
            // R9
            chk("R9 b side", {15'b0, qcs_b, qodt_b, qcke_b, q_b}, 32'h0);
        end

        // R3: cs_aux tied low, cs_main high keeps loading
        step(1'b1, 1'b0, 1'b0, 1'b0, 25'h0F0F0F0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 25'h1234567);
        chk("R3 aux low loads", {7'b0, q_a}, 32'h1234567);

        // R5: asynchronous reset mid-cycle with gating active
        cs_main = 1'b1; cs_aux = 1'b1; odt_in = 1'b1; cke_in = 1'b1;
        #1;
        rst_n = 1'b0;
        #1;
        all_low("R5 async clear");
        @(negedge clk);
        all_low("R5 held with gating");

        // R10: release with low inputs
        cs_main = 1'b0; cs_aux = 1'b0; odt_in = 1'b0; cke_in = 1'b0; d_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        all_low("R10 quiet release 1");
        @(negedge clk);
        all_low("R10 quiet release 2");

        // R6: front layout
        set_mode(1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0, {11'h7FF, 14'h1A5C});
        chk("R6 q_a", {7'b0, q_a}, 32'h0001A5C);
        chk("R6 q_b", {18'b0, q_b}, 32'h1A5C);
        chk("R6 b ctrl", {29'b0, qcs_b, qodt_b, qcke_b}, {29'b0, qcs_a, qodt_a, qcke_a});
        chk("R6 odt b", {31'b0, qodt_b}, 32'h1);

        // R7: back layout with reversal, then gating hold
        set_mode(1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1, {11'h555, 14'h1A5C});
        chk("R7 q_a", {7'b0, q_a}, 32'h0000E96);
        chk("R7 q_b", {18'b0, q_b}, 32'h0E96);
        chk("R7 cke b", {31'b0, qcke_b}, 32'h1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 25'h0000001);
        chk("R7 bit0 to top", {18'b0, q_b}, 32'h2000);
        step(1'b1, 1'b1, 1'b1, 1'b0, 25'h0003FFE);
        chk("R2 hold in back", {18'b0, q_b}, 32'h2000);
        chk("R4 cs b in back", {30'b0, qcs_b, qodt_b}, 32'h3);

        // R8: reserved code
        set_mode(1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 25'h1FFFFFF);
        chk("R8 q_a", {7'b0, q_a}, 32'h0);
        chk("R8 q_b", {18'b0, q_b}, 32'h0);
        chk("R8 b ctrl", {29'b0, qcs_b, qodt_b, qcke_b}, 32'h0);
        chk("R8 a ctrl", {29'b0, qcs_a, qodt_a, qcke_a}, 32'h3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule